// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block drives the master side of an SPI link. It produces the serial clock, the chip-select line and the bit timing for each frame. Whole frames are popped from a transmit queue, and assembled received frames are pushed into a receive queue. Both queues use valid/ready ports. The block counts frames against a programmed transfer length. It raises a one-cycle pulse when the transfer completes and another when it suspends.

Software arms a transfer with a start pulse. It can insert idle time after select assertion and between frames, and it can pulse select between frames. A suspend request is honoured at the next frame boundary. When the receive queue fills, the clock can be held until space returns. Clock polarity, sampling phase, bit order, frame width (4 to 32 bits) and a power-of-two clock divider are all run-time settings.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset, and whenever no transfer is active (`running` low), `ss` sits at its inactive level and `sck` sits at `cpol`.
- R2: A frame is `frame_bits`+1 bits long. With `lsb_first`=0, bit `frame_bits` of the transmit word is sent first; with `lsb_first`=1, bit 0 is sent first. The received frame is right-aligned in `rx_data`, with its bits placed by the same order and all bits above the frame width at zero.
- R3: `sck` idles at `cpol`. With `cpha`=0, data is sampled on the first clock edge of each bit. With `cpha`=1, it is sampled on the second edge. `mosi` is stable at every sampling edge.
- R4: Each half period of `sck` lasts 2^`baud` kernel cycles. When `bypass`=1, it lasts one kernel cycle whatever `baud` holds.
- R5: When `sel_en`=1, a transfer takes exactly 2·`lead_gap` half periods longer than with `lead_gap`=0. When `sel_en`=0, `lead_gap` has no effect and `ss` stays inactive.
- R6: Between consecutive frames of a transfer, exactly 2·`frame_gap` extra half periods of idle clock are inserted.
- R7: With `sel_pulse`=1 and `frame_gap`>1, `ss` goes inactive during every inter-frame gap and is asserted once per frame. Otherwise `ss` is asserted once for the whole transfer.
- R8: After `xfer_size` frames (when non-zero), `eot` pulses for one cycle, `running` clears and `ss` goes inactive.
- R9: With `xfer_size`=0, the transfer never ends by count, and `eot` never pulses.
- R10: A `susp_req` during a frame lets that frame finish. No further frame starts. `susp` then pulses, `running` clears and `ss` goes inactive. A request outside a frame takes effect at once.
- R11: With `auto_susp`=1, no frame starts while `rx_ready` is low. `susp` pulses once, `running` stays high, and the transfer resumes when `rx_ready` returns. With `auto_susp`=0, frames continue and pushes made while `rx_ready` is low are lost.
- R12: With `tx_en`=1, a frame starts only when `tx_valid` is high, and each frame pops one word. With `tx_en`=0, frames run without popping, and `mosi` stays 0.
- R13: Driving `en` low returns the block to idle within one clock: `running` clears and `ss` goes inactive. `start` is ignored while `en` is low.
- R14: `sel_pol` sets the active level of `ss`: 1 for active-high, 0 for active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low forces idle |
| start | input | 1 | Pulse: begin a transfer |
| susp_req | input | 1 | Pulse: suspend after the current frame |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: sample on first edge, 1: on second edge |
| lsb_first | input | 1 | Bit order select |
| baud | input | 3 | Half period = 2^baud kernel cycles |
| bypass | input | 1 | Force a one-cycle half period |
| frame_bits | input | 5 | Frame width minus one (3 to 31) |
| xfer_size | input | 16 | Frames per transfer, 0 = endless |
| lead_gap | input | 4 | SPI periods between select assertion and first frame |
| frame_gap | input | 4 | SPI periods of idle between frames |
| sel_pulse | input | 1 | Release select in gaps longer than one period |
| sel_en | input | 1 | Enable select output driving |
| sel_pol | input | 1 | Select active level |
| auto_susp | input | 1 | Hold clock while the receive queue is full |
| tx_en | input | 1 | Transmit path enable |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| rx_data | output | 32 | Received frame, right-aligned |
| rx_valid | output | 1 | Push strobe for the receive queue |
| rx_ready | input | 1 | Receive queue has space |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss | output | 1 | Chip select |
| running | output | 1 | Transfer active (start bit) |
| eot | output | 1 | End-of-transfer pulse |
| susp | output | 1 | Suspension pulse |

## Verification
The bench keeps the default 32-bit data path and 16-bit counter, so every frame width from 4 to 32 bits can be selected at run time. The checks exercise 8-bit, 12-bit and full 32-bit frames on the same instance. The serial loop is closed with `miso` inverted from `mosi`, so the received value always differs from the transmitted one, and bit-order faults on either path show up. Gap and lead timing are checked by comparing whole-transfer durations at two settings, under divider values that make the expected cycle difference unambiguous.

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic          susp_req,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic [2:0]    baud,
  input  logic          bypass,
  input  logic [$clog2(DW)-1:0] frame_bits,
  input  logic [CW-1:0] xfer_size,
  input  logic [3:0]    lead_gap,
  input  logic [3:0]    frame_gap,
  input  logic          sel_pulse,
  input  logic          sel_en,
  input  logic          sel_pol,
  input  logic          auto_susp,
  input  logic          tx_en,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          ss,
  output logic          running,
  output logic          eot,
  output logic          susp
);
  localparam int IW = $clog2(DW);
  localparam int HW = (IW + 1 > 5) ? IW + 1 : 5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_WAIT, S_XFER, S_GAP} st_t;

  st_t           st;
  logic [7:0]    hcnt;
  logic [HW-1:0] h;
  logic [DW-1:0] txw, rxw;
  logic [CW-1:0] cnt;
  logic          pend, hold;

  logic [7:0]    half_m1;
  logic          timed, tick, gap_end, last_half, fin, go, ss_on;
  logic [3:0]    gsel;
  logic [IW-1:0] bit_i, idx;

  assign half_m1   = bypass ? 8'd0 : 8'((9'd1 << baud) - 9'd1);
  assign timed     = (st == S_LEAD) || (st == S_XFER) || (st == S_GAP);
  assign tick      = timed && (hcnt == half_m1);
  assign gsel      = (st == S_LEAD) ? lead_gap : frame_gap;
  assign gap_end   = (h == HW'({gsel, 1'b0}) - HW'(1));
  assign last_half = (h == HW'({frame_bits, 1'b1}));
  assign bit_i     = h[IW:1];
  assign idx       = lsb_first ? bit_i : frame_bits - bit_i;
  assign fin       = (xfer_size != '0) && (cnt + CW'(1) == xfer_size);
  assign go        = en && (st == S_WAIT) && !pend && (!auto_susp || rx_ready)
                     && (!tx_en || tx_valid);
  assign tx_ready  = go && tx_en;

  assign ss_on = sel_en && ((st == S_LEAD) || (st == S_WAIT) || (st == S_XFER) ||
                 ((st == S_GAP) && !(sel_pulse && frame_gap > 4'd1)));
  assign ss    = sel_pol ? ss_on : !ss_on;
  assign sck   = cpol ^ ((st == S_XFER) && (h[0] ^ cpha));
  assign mosi  = (st == S_XFER) && txw[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hcnt <= '0; h <= '0; txw <= '0; rxw <= '0; cnt <= '0;
      pend <= 1'b0; hold <= 1'b0; running <= 1'b0; eot <= 1'b0; susp <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      eot <= 1'b0;
      susp <= 1'b0;
      rx_valid <= 1'b0;
      hcnt <= (tick || !timed) ? 8'd0 : hcnt + 8'd1;
      if (susp_req && running) pend <= 1'b1;
      if (!en) begin
        st <= S_IDLE; running <= 1'b0; pend <= 1'b0; hold <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            running <= 1'b1; cnt <= '0; h <= '0; pend <= 1'b0; hold <= 1'b0;
            st <= (sel_en && lead_gap != 4'd0) ? S_LEAD : S_WAIT;
          end
          S_LEAD, S_GAP: begin
            if (pend) begin
              susp <= 1'b1; running <= 1'b0; pend <= 1'b0; st <= S_IDLE;
            end else if (tick) begin
              if (gap_end) begin st <= S_WAIT; h <= '0; end
              else h <= h + HW'(1);
            end
          end
          S_WAIT: begin
            if (pend) begin
              susp <= 1'b1; running <= 1'b0; pend <= 1'b0; st <= S_IDLE;
            end else if (auto_susp && !rx_ready) begin
              if (!hold) susp <= 1'b1;
              hold <= 1'b1;
            end else begin
              hold <= 1'b0;
              if (go) begin
                st <= S_XFER; h <= '0; rxw <= '0;
                txw <= tx_en ? tx_data : '0;
              end
            end
          end
          S_XFER: if (tick) begin
            if (!h[0]) rxw[idx] <= miso;
            if (last_half) begin
              rx_valid <= 1'b1; rx_data <= rxw; cnt <= cnt + CW'(1);
              if (fin) begin
                eot <= 1'b1; running <= 1'b0; st <= S_IDLE;
              end else if (pend) begin
                susp <= 1'b1; running <= 1'b0; pend <= 1'b0; st <= S_IDLE;
              end else if (frame_gap != 4'd0) begin
                st <= S_GAP; h <= '0;
              end else st <= S_WAIT;
            end else h <= h + HW'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          cpol,
  input logic          sel_pol,
  input logic          tx_en,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [CW-1:0] xfer_size,
  input logic          sck,
  input logic          ss,
  input logic          running,
  input logic          eot
);
  a_r1_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (ss == !sel_pol));

  a_r3_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (sck == cpol));

  a_r13_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!running && ss == !sel_pol));

  a_r8_eot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> !running);

  a_r8_eot_single: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);

  a_r12_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && tx_en));

  a_r9_endless_no_eot: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_size == '0 && $past(xfer_size) == '0) |-> !eot);
endmodule

bind spi_xfer_seq spi_xfer_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .sel_pol(sel_pol),
  .tx_en(tx_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .xfer_size(xfer_size), .sck(sck), .ss(ss), .running(running), .eot(eot)
);

// File: tb/spi_xfer_seq_bench.sv
`timescale 1ns/1ps
module spi_xfer_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en, start, susp_req, cpol, cpha, lsb_first, bypass;
  logic [2:0] baud;
  logic [4:0] frame_bits;
  logic [15:0] xfer_size;
  logic [3:0] lead_gap, frame_gap;
  logic sel_pulse, sel_en, sel_pol, auto_susp, tx_en;
  logic [31:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, rx_ready, miso, sck, mosi, ss, running, eot, susp;

  always #2.5 clk = ~clk;

  logic [31:0] txq [16];
  int txn, txi;
  assign tx_valid = (txi < txn);
  assign tx_data  = txq[txi[3:0]];
  assign miso     = ~mosi;
  always @(posedge clk) if (tx_valid && tx_ready) txi <= txi + 1;

  spi_xfer_seq u_spi_xfer_seq (.*);

  int nchk = 0, nbad = 0;
  int nbits, nedge, imin, imax, last_e, eot_n, susp_n, nrxv, rxn, ss_on_n, cyc = 0;
  logic [31:0] bits;
  logic [31:0] rxq [16];
  logic psck, pss;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sck !== psck) begin
      nedge++;
      if (last_e >= 0) begin
        if (cyc - last_e < imin) imin = cyc - last_e;
        if (cyc - last_e > imax) imax = cyc - last_e;
      end
      last_e = cyc;
      if (sck == !(cpol ^ cpha)) begin bits = {bits[30:0], mosi}; nbits++; end
    end
    if (ss !== pss && ss === sel_pol) ss_on_n++;
    if (eot) eot_n++;
    if (susp) susp_n++;
    if (rx_valid) begin
      nrxv++;
      if (rx_ready && rxn < 16) begin rxq[rxn] = rx_data; rxn++; end
    end
    psck = sck; pss = ss;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] rev(input logic [31:0] v, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  task automatic defaults();
    en = 1; start = 0; susp_req = 0; cpol = 0; cpha = 0; lsb_first = 0; baud = 0;
    bypass = 0; frame_bits = 7; xfer_size = 1; lead_gap = 0; frame_gap = 0;
    sel_pulse = 0; sel_en = 1; sel_pol = 0; auto_susp = 0; tx_en = 1; rx_ready = 1;
  endtask

  task automatic clr(input int n, input logic [31:0] w0, input logic [31:0] w1,
                     input logic [31:0] w2);
    txq[0] = w0; txq[1] = w1; txq[2] = w2;
    for (int i = 3; i < 16; i++) txq[i] = 32'h5A5A_0000 + 32'(i);
    txn = n; txi <= 0;
    nbits = 0; bits = 0; nedge = 0; imin = 9999; imax = 0; last_e = -1;
    eot_n = 0; susp_n = 0; nrxv = 0; rxn = 0; ss_on_n = 0;
  endtask

  task automatic run(output int dur);
    start = 1; step(1); start = 0; dur = 1;
    while (!eot && dur < 8000) begin step(1); dur++; end
    step(2);
  endtask

  task automatic t_reset();
    defaults(); en = 0;
    step(2);
    chk("R1 ss idle after reset", {31'd0, ss}, 32'd1);
    chk("R1 sck idle after reset", {31'd0, sck}, 32'd0);
    chk("R1 running after reset", {31'd0, running}, 32'd0);
    en = 1; step(1);
  endtask

  task automatic t_basic();
    int d;
    defaults(); xfer_size = 2; clr(2, 32'hA5, 32'h3C, 0); step(1);
    run(d);
    chk("R2 msb-first bits", bits[15:0], 16'hA53C);
    chk("R2 bit count", nbits, 16);
    chk("R2 rx frame 0", rxq[0], 32'h5A);
    chk("R2 rx frame 1", rxq[1], 32'hC3);
    chk("R8 one eot", eot_n, 1);
    chk("R8 running cleared", {31'd0, running}, 0);
    chk("R8 ss released", {31'd0, ss}, 1);
    chk("R3 sck idles low", {31'd0, sck}, 0);
  endtask

  task automatic t_lsb();
    int d;
    defaults(); cpol = 1; cpha = 1; lsb_first = 1; frame_bits = 11;
    clr(1, 32'hFFFF_FB2D, 0, 0); step(1);
    run(d);
    chk("R2 lsb-first bits", bits[11:0], rev(32'hB2D, 12));
    chk("R2 rx 12-bit right aligned", rxq[0], 32'h4D2);
    chk("R3 sck idles high", {31'd0, sck}, 1);
    defaults(); frame_bits = 31; cpha = 1; clr(1, 32'hDEADBEEF, 0, 0); step(1);
    run(d);
    chk("R2 32-bit frame bits", bits, 32'hDEADBEEF);
    chk("R2 32-bit rx", rxq[0], 32'h21524110);
  endtask

  task automatic t_baud();
    int d;
    defaults(); baud = 2; clr(1, 32'h96, 0, 0); step(1);
    run(d);
    chk("R4 half period min baud2", imin, 4);
    chk("R4 half period max baud2", imax, 4);
    defaults(); baud = 5; bypass = 1; clr(1, 32'h96, 0, 0); step(1);
    run(d);
    chk("R4 bypass half period", imax, 1);
    chk("R3 edge count", nedge, 16);
  endtask

  task automatic t_lead();
    int d0, d3, doff;
    defaults(); baud = 1; clr(1, 32'h11, 0, 0); step(1); run(d0);
    defaults(); baud = 1; lead_gap = 3; clr(1, 32'h11, 0, 0); step(1); run(d3);
    chk("R5 lead adds 2*3 halves", d3 - d0, 12);
    defaults(); baud = 1; lead_gap = 3; sel_en = 0; clr(1, 32'h11, 0, 0); step(1); run(doff);
    chk("R5 lead ignored without select", doff, d0);
    chk("R5 select stays inactive", ss_on_n, 0);
  endtask

  task automatic t_gap();
    int d0, d5;
    defaults(); baud = 1; xfer_size = 2; clr(2, 1, 2, 0); step(1); run(d0);
    defaults(); baud = 1; xfer_size = 2; frame_gap = 5; clr(2, 1, 2, 0); step(1); run(d5);
    chk("R6 gap adds 2*5 halves", d5 - d0, 20);
  endtask

  task automatic t_selpulse();
    int d;
    defaults(); xfer_size = 3; frame_gap = 2; sel_pulse = 1; clr(3, 1, 2, 3); step(1); run(d);
    chk("R7 select pulses per frame", ss_on_n, 3);
    defaults(); xfer_size = 3; frame_gap = 1; sel_pulse = 1; clr(3, 1, 2, 3); step(1); run(d);
    chk("R7 short gap keeps select", ss_on_n, 1);
    defaults(); xfer_size = 3; frame_gap = 2; clr(3, 1, 2, 3); step(1); run(d);
    chk("R7 no pulse mode keeps select", ss_on_n, 1);
  endtask

  task automatic t_endless();
    defaults(); xfer_size = 0; clr(5, 1, 2, 3); step(1);
    start = 1; step(1); start = 0;
    step(200);
    chk("R9 five frames done", nrxv, 5);
    chk("R9 no eot", eot_n, 0);
    chk("R9 still running", {31'd0, running}, 1);
    susp_req = 1; step(1); susp_req = 0; step(3);
    chk("R10 suspend idle", susp_n, 1);
    chk("R10 running cleared", {31'd0, running}, 0);
    chk("R10 ss released", {31'd0, ss}, 1);
  endtask

  task automatic t_susp_mid();
    int t;
    defaults(); xfer_size = 0; baud = 1; clr(2, 32'hF0, 32'h0F, 0); step(1);
    start = 1; step(1); start = 0;
    t = 0; while (nbits < 3 && t < 500) begin step(1); t++; end
    susp_req = 1; step(1); susp_req = 0;
    t = 0; while (running && t < 500) begin step(1); t++; end
    step(2);
    chk("R10 frame completes", nbits, 8);
    chk("R10 one frame received", nrxv, 1);
    chk("R10 one suspend pulse", susp_n, 1);
    chk("R10 second word not popped", txi, 1);
  endtask

  task automatic t_txwait();
    int t;
    defaults(); xfer_size = 2; clr(1, 32'h81, 0, 0); step(1);
    start = 1; step(1); start = 0;
    step(100);
    chk("R12 waits for data", nbits, 8);
    chk("R12 still running", {31'd0, running}, 1);
    txq[1] = 32'h42; txn = 2;
    t = 0; while (eot_n == 0 && t < 500) begin step(1); t++; end
    chk("R12 resumes with data", bits[15:0], 16'h8142);
    defaults(); xfer_size = 2; tx_en = 0; clr(0, 0, 0, 0); step(1);
    run(t);
    chk("R12 rx-only frames", nrxv, 2);
    chk("R12 mosi held low", bits[15:0], 16'h0000);
    chk("R12 rx-only data", rxq[1], 32'hFF);
    chk("R12 no pops", txi, 0);
  endtask

  task automatic t_auto();
    int t;
    defaults(); xfer_size = 3; auto_susp = 1; rx_ready = 0; clr(3, 1, 2, 3); step(1);
    start = 1; step(1); start = 0;
    step(60);
    chk("R11 held with full queue", nbits, 0);
    chk("R11 one suspend pulse", susp_n, 1);
    chk("R11 running while held", {31'd0, running}, 1);
    rx_ready = 1;
    t = 0; while (eot_n == 0 && t < 1000) begin step(1); t++; end
    chk("R11 resumed to end", rxn, 3);
    chk("R11 no extra suspend", susp_n, 1);
    defaults(); xfer_size = 2; rx_ready = 0; clr(2, 1, 2, 0); step(1);
    run(t);
    chk("R11 frames lost without auto", rxn, 0);
    chk("R11 pushes continue", nrxv, 2);
  endtask

  task automatic t_disable();
    int t;
    defaults(); xfer_size = 0; baud = 2; clr(4, 1, 2, 3); step(1);
    start = 1; step(1); start = 0;
    t = 0; while (nbits < 2 && t < 500) begin step(1); t++; end
    en = 0; step(1);
    chk("R13 ss released in one clock", {31'd0, ss}, 1);
    chk("R13 running cleared", {31'd0, running}, 0);
    chk("R13 sck idle", {31'd0, sck}, 0);
    start = 1; step(1); start = 0; step(5);
    chk("R13 start ignored when off", {31'd0, running}, 0);
    en = 1; step(1);
  endtask

  task automatic t_pol();
    int t;
    defaults(); sel_pol = 1; step(2);
    chk("R14 active-high idle", {31'd0, ss}, 0);
    baud = 3; clr(1, 32'h33, 0, 0); step(1);
    start = 1; step(1); start = 0; step(20);
    chk("R14 active-high asserted", {31'd0, ss}, 1);
    t = 0; while (running && t < 1000) begin step(1); t++; end
    chk("R14 released after end", {31'd0, ss}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    defaults(); clr(0, 0, 0, 0);
    psck = 0; pss = 1;
    step(3); rst_n = 1;
    t_reset();
    t_basic();
    t_lsb();
    t_baud();
    t_lead();
    t_gap();
    t_selpulse();
    t_endless();
    t_susp_mid();
    t_txwait();
    t_auto();
    t_disable();
    t_pol();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule